// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift and rotate datapath of a 64-bit integer core. It is purely combinational. It takes a register value, an 8-bit count, an operation code and an operand-size select, together with the current condition flags. It returns the value to write back to the destination register, the new flags and a flag-write strobe. Eight operations are provided: two spellings of the left shift, a logical and an arithmetic right shift, two plain rotates, and two rotates that pass through the carry flag.

A masked count of zero still writes the register. For a 32-bit operand the upper half of the destination is cleared for every count, zero included. Only the flags stay untouched in that case. The unit has no state, so it has no states or transitions to list. The operation code selects one of two datapaths, a shifter and a rotator, and a small count stage in front of them feeds both.

Top module: `shrot_unit`

## Requirements
- R1: The count is masked to `shamt[5:0]` when `wide_op`=1 (64-bit) and to `shamt[4:0]` when `wide_op`=0 (32-bit); higher count bits have no effect.
- R2: `op_sel` encoding: 0 SHL, 1 SAL, 2 SHR, 3 SAR, 4 ROL, 5 ROR, 6 RCL, 7 RCR; SAL gives outputs identical to SHL.
- R3: SHL/SAL fill with zeros from the bottom and set CF to the last bit moved out of the top of the operand; SHR fills with zeros and SAR fills with copies of the operand's sign bit from the top, and both set CF to the last bit moved out of the bottom.
- R4: With a masked count of zero, `flags_out` equals `flags_in` and `flags_we`=0; otherwise `flags_we`=1.
- R5: With `wide_op`=0, `res_val[63:32]` is zero for every count, zero included (source FFFFFFFF_00000001, SHL, count 0 gives 00000000_00000001).
- R6: ROL and ROR rotate within the operand width, and CF is set to the bit that wrapped around last.
- R7: RCL and RCR rotate the (width+1)-bit value formed by CF above the operand; the new CF is that value's top bit after the rotate.
- R8: For shifts with a nonzero masked count, SF is the result's top bit, ZF is set when the result is zero within the operand width, and PF is set when `res_val[7:0]` has an even number of ones.
- R9: Rotates with a nonzero masked count pass SF, ZF and PF through from `flags_in`.
- R10: For a masked count of 1, OF is: SHL, SAL, ROL and RCL give result top bit XOR new CF; SHR gives the source's top bit; SAR gives 0; ROR and RCR give the XOR of the two top result bits. The same formula drives OF for larger counts.

Flag bit positions in `flags_in` and `flags_out` are: [0] CF, [1] PF, [2] ZF, [3] SF, [4] OF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (see R2) |
| wide_op | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| src_val | input | 64 | Destination register value before the operation |
| shamt | input | 8 | Unmasked shift or rotate count |
| flags_in | input | 5 | Current flags {OF,SF,ZF,PF,CF} |
| res_val | output | 64 | Value written back to the register |
| flags_out | output | 5 | New flags {OF,SF,ZF,PF,CF} |
| flags_we | output | 1 | High when the flags are updated |

## Verification
The embedded assertions are evaluated on every input change. They check that a zero masked count leaves the flags untouched and the write strobe low, that the upper half is clear for every 32-bit operation, that rotates never alter SF, ZF or PF, and that ZF agrees with the shift result. Only the directed scenarios can show the actual data movement: the carry chosen by each operation, sign fill, rotation through carry, count masking with the high count bits set, the SAL and SHL equivalence, and OF for a count of 1. The bench compares all of these against a bit-serial reference model.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SAL = 3'd1,
        OP_SHR = 3'd2,
        OP_SAR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } shrot_op_e;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_ZF = 2;
    localparam int FL_SF = 3;
    localparam int FL_OF = 4;
    localparam int FL_W  = 5;
endpackage

// File: rtl/shrot_count_mask.sv
module shrot_count_mask #(
    parameter int CNT_W = 8,
    parameter int SH_W  = 6
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             wide,
    output logic [SH_W-1:0]  amt,
    output logic             amt_zero
);
    // Count bits above the mask never reach the datapath (R1).
    logic [CNT_W-SH_W-1:0] unused_hi;

    always_comb begin
        unused_hi = cnt[CNT_W-1:SH_W];
        if (wide)
            amt = cnt[SH_W-1:0];
        else
            amt = {1'b0, cnt[SH_W-2:0]};
        amt_zero = (amt == '0);
    end
endmodule

// File: rtl/shrot_shifter.sv
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SH_W = 6
) (
    input  shrot_op_e        op,
    input  logic             wide,
    input  logic [XLEN-1:0]  src,
    input  logic [SH_W-1:0]  amt,
    output logic [XLEN-1:0]  res,
    output logic             cf
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0]        opnd_z;
    logic [XLEN-1:0]        opnd_s;
    logic [XLEN:0]          left_w;
    logic [XLEN:0]          right_z;
    logic signed [XLEN:0]   right_s;
    logic [XLEN-1:0]        raw;

    always_comb begin
        opnd_z  = wide ? src : {{HALF{1'b0}}, src[HALF-1:0]};
        opnd_s  = wide ? src : {{HALF{src[HALF-1]}}, src[HALF-1:0]};
        // One spare bit catches the last bit moved out at either end.
        left_w  = {1'b0, opnd_z} << amt;
        right_z = {opnd_z, 1'b0} >> amt;
        right_s = $signed({opnd_s, 1'b0}) >>> amt;
        unique case (op)
            OP_SHL, OP_SAL: begin
                raw = left_w[XLEN-1:0];
                cf  = wide ? left_w[XLEN] : left_w[HALF];
            end
            OP_SHR: begin
                raw = right_z[XLEN:1];
                cf  = right_z[0];
            end
            default: begin
                raw = right_s[XLEN:1];
                cf  = right_s[0];
            end
        endcase
        res = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end
endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator
    import shrot_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SH_W = 6
) (
    input  shrot_op_e        op,
    input  logic             wide,
    input  logic [XLEN-1:0]  src,
    input  logic [SH_W-1:0]  amt,
    input  logic             cf_in,
    output logic [XLEN-1:0]  res,
    output logic             cf
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] h;
    logic [XLEN-1:0] rol_w, ror_w, unused_a, unused_b;
    logic [HALF-1:0] rol_h, ror_h, unused_c, unused_d;
    logic [XLEN:0]   rcl_w, rcr_w, unused_e, unused_f;
    logic [HALF:0]   rcl_h, rcr_h, unused_g, unused_k;
    logic [XLEN:0]   pick;

    always_comb begin
        h = src[HALF-1:0];
        {rol_w, unused_a} = {src, src} << amt;
        {unused_b, ror_w} = {src, src} >> amt;
        {rol_h, unused_c} = {h, h} << amt;
        {unused_d, ror_h} = {h, h} >> amt;
        // Carry rotates work on CF placed above the operand.
        {rcl_w, unused_e} = {cf_in, src, cf_in, src} << amt;
        {unused_f, rcr_w} = {cf_in, src, cf_in, src} >> amt;
        {rcl_h, unused_g} = {cf_in, h, cf_in, h} << amt;
        {unused_k, rcr_h} = {cf_in, h, cf_in, h} >> amt;
        unique case (op)
            OP_ROL: pick = wide ? {rol_w[0], rol_w}
                                : {{(HALF+1){1'b0}}, rol_h};
            OP_ROR: pick = wide ? {ror_w[XLEN-1], ror_w}
                                : {{(HALF+1){1'b0}}, ror_h};
            OP_RCL: pick = wide ? rcl_w : {{HALF{1'b0}}, rcl_h};
            default: pick = wide ? rcr_w : {{HALF{1'b0}}, rcr_h};
        endcase
        if (wide) begin
            res = pick[XLEN-1:0];
            cf  = pick[XLEN];
        end else begin
            res = {{HALF{1'b0}}, pick[HALF-1:0]};
            if (op == OP_ROL)
                cf = pick[0];
            else if (op == OP_ROR)
                cf = pick[HALF-1];
            else
                cf = pick[HALF];
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 8
) (
    input  logic [2:0]        op_sel,
    input  logic              wide_op,
    input  logic [XLEN-1:0]   src_val,
    input  logic [CNT_W-1:0]  shamt,
    input  logic [FL_W-1:0]   flags_in,
    output logic [XLEN-1:0]   res_val,
    output logic [FL_W-1:0]   flags_out,
    output logic              flags_we
);
    localparam int HALF = XLEN / 2;
    localparam int SH_W = $clog2(XLEN);

    shrot_op_e       op;
    logic [SH_W-1:0] amt;
    logic            amt_zero;
    logic [XLEN-1:0] sh_res, rt_res, r;
    logic            sh_cf, rt_cf, new_cf, top, top2, is_rot;

    assign op = shrot_op_e'(op_sel);

    shrot_count_mask #(.CNT_W(CNT_W), .SH_W(SH_W)) u_mask (
        .cnt(shamt), .wide(wide_op), .amt(amt), .amt_zero(amt_zero)
    );

    shrot_shifter #(.XLEN(XLEN), .SH_W(SH_W)) u_shift (
        .op(op), .wide(wide_op), .src(src_val), .amt(amt),
        .res(sh_res), .cf(sh_cf)
    );

    shrot_rotator #(.XLEN(XLEN), .SH_W(SH_W)) u_rot (
        .op(op), .wide(wide_op), .src(src_val), .amt(amt),
        .cf_in(flags_in[FL_CF]), .res(rt_res), .cf(rt_cf)
    );

    always_comb begin
        is_rot = op_sel[2];
        r      = is_rot ? rt_res : sh_res;
        new_cf = is_rot ? rt_cf : sh_cf;
        top    = wide_op ? r[XLEN-1] : r[HALF-1];
        top2   = wide_op ? r[XLEN-2] : r[HALF-2];
        flags_out = flags_in;
        if (amt_zero) begin
            res_val  = wide_op ? src_val : {{HALF{1'b0}}, src_val[HALF-1:0]};
            flags_we = 1'b0;
        end else begin
            res_val  = r;
            flags_we = 1'b1;
            flags_out[FL_CF] = new_cf;
            unique case (op)
                OP_SHR:         flags_out[FL_OF] = wide_op ? src_val[XLEN-1]
                                                           : src_val[HALF-1];
                OP_SAR:         flags_out[FL_OF] = 1'b0;
                OP_ROR, OP_RCR: flags_out[FL_OF] = top ^ top2;
                default:        flags_out[FL_OF] = top ^ new_cf;
            endcase
            if (!is_rot) begin
                flags_out[FL_SF] = top;
                flags_out[FL_ZF] = (r == '0);
                flags_out[FL_PF] = ~^r[7:0];
            end
        end
    end

    always_comb begin
        // R4
        no_flag_write_chk: assert (!amt_zero ||
                                   (flags_out == flags_in && !flags_we))
            else $error("flags changed on zero count");
        // R5
        upper_clear_chk: assert (wide_op || res_val[XLEN-1:HALF] == '0)
            else $error("upper half not cleared");
        // R9
        rot_flag_pass_chk: assert (amt_zero || !op_sel[2] ||
            flags_out[FL_SF:FL_PF] == flags_in[FL_SF:FL_PF])
            else $error("rotate changed SF/ZF/PF");
        // R8
        shift_zero_chk: assert (amt_zero || op_sel[2] ||
            flags_out[FL_ZF] == ((wide_op ? res_val : {{HALF{1'b0}}, res_val[HALF-1:0]}) == '0))
            else $error("ZF disagrees with shift result");
    end
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic [2:0]  op_sel;
    logic        wide_op;
    logic [63:0] src_val;
    logic [7:0]  shamt;
    logic [4:0]  flags_in;
    logic [63:0] res_val;
    logic [4:0]  flags_out;
    logic        flags_we;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    shrot_unit u0 (
        .op_sel(op_sel), .wide_op(wide_op), .src_val(src_val), .shamt(shamt),
        .flags_in(flags_in), .res_val(res_val), .flags_out(flags_out),
        .flags_we(flags_we)
    );

    function automatic void ref_model(input int op, input bit wd,
            input logic [63:0] s, input logic [7:0] c, input logic [4:0] fi,
            output logic [63:0] res, output logic [4:0] fo, output bit we);
        int          w = wd ? 64 : 32;
        int          n = wd ? (c & 63) : (c & 31);
        logic [63:0] m = wd ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        logic [63:0] v = s & m;
        logic        cf = fi[0];
        logic        t;
        for (int i = 0; i < n; i++) begin
            case (op)
                0, 1: begin cf = v[w-1]; v = (v << 1) & m; end
                2:    begin cf = v[0]; v = v >> 1; end
                3:    begin cf = v[0]; t = v[w-1]; v = (v >> 1) | (64'(t) << (w-1)); end
                4:    begin t = v[w-1]; v = ((v << 1) | 64'(t)) & m; cf = t; end
                5:    begin t = v[0]; v = (v >> 1) | (64'(t) << (w-1)); cf = t; end
                6:    begin t = v[w-1]; v = ((v << 1) | 64'(cf)) & m; cf = t; end
                default: begin t = v[0]; v = (v >> 1) | (64'(cf) << (w-1)); cf = t; end
            endcase
        end
        res = v;
        fo  = fi;
        we  = (n != 0);
        if (n != 0) begin
            fo[0] = cf;
            case (op)
                2:       fo[4] = s[w-1];
                3:       fo[4] = 1'b0;
                5, 7:    fo[4] = v[w-1] ^ v[w-2];
                default: fo[4] = v[w-1] ^ cf;
            endcase
            if (op < 4) begin
                fo[3] = v[w-1];
                fo[2] = (v == 0);
                fo[1] = ~^v[7:0];
            end
        end
    endfunction

    task automatic chk(input string req, input logic [63:0] got,
                       input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h (op=%0d wide=%0d src=%h cnt=%0d)",
                     req, got, exp, op_sel, wide_op, src_val, shamt);
        end
    endtask

    task automatic drive(input int op, input bit wd, input logic [63:0] s,
                         input logic [7:0] c, input logic [4:0] fi);
        @(negedge clk);
        op_sel = 3'(op); wide_op = wd; src_val = s; shamt = c; flags_in = fi;
        #1;
    endtask

    task automatic compare_ref();
        logic [63:0] er; logic [4:0] ef; bit ew; int n;
        ref_model(int'(op_sel), wide_op, src_val, shamt, flags_in, er, ef, ew);
        n = wide_op ? (shamt & 63) : (shamt & 31);
        chk(op_sel >= 6 ? "R7" : (op_sel >= 4 ? "R6" : "R3"), res_val, er);
        chk("R5", {63'b0, wide_op || res_val[63:32] == 0}, 64'd1);
        chk("R4", {63'b0, flags_we}, {63'b0, ew});
        chk(op_sel >= 4 ? "R7" : "R3", {63'b0, flags_out[0]}, {63'b0, ef[0]});
        chk(op_sel >= 4 ? "R9" : "R8", {61'b0, flags_out[3:1]}, {61'b0, ef[3:1]});
        if (n <= 1) chk("R10", {63'b0, flags_out[4]}, {63'b0, ef[4]});
    endtask

    task automatic t_quiet();
        drive(0, 1'b1, 64'd0, 8'd0, 5'd0);
        chk("R4", {58'b0, flags_out, flags_we}, 64'd0);
        chk("R4", res_val, 64'd0);
    endtask

    task automatic t_zero_count_upper();
        drive(0, 1'b0, 64'hFFFF_FFFF_0000_0001, 8'd0, 5'b10101);
        chk("R5", res_val, 64'h0000_0000_0000_0001);
        chk("R4", {58'b0, flags_out, flags_we}, {58'b0, 5'b10101, 1'b0});
        drive(3, 1'b0, 64'h1234_5678_8000_0000, 8'd32, 5'b01010);
        chk("R1", res_val, 64'h0000_0000_8000_0000);
        chk("R1", {59'b0, flags_out}, {59'b0, 5'b01010});
        drive(2, 1'b1, 64'hDEAD_BEEF_0000_0000, 8'd64, 5'b00001);
        chk("R1", res_val, 64'hDEAD_BEEF_0000_0000);
    endtask

    task automatic t_mask_high_bits();
        drive(0, 1'b1, 64'h1, 8'hC3, 5'd0);
        chk("R1", res_val, 64'h8);
        drive(0, 1'b0, 64'h1, 8'hE4, 5'd0);
        chk("R1", res_val, 64'h10);
    endtask

    task automatic t_sal_matches_shl();
        logic [63:0] r0; logic [4:0] f0;
        drive(0, 1'b1, 64'hC000_0000_0000_0001, 8'd1, 5'b00100);
        r0 = res_val; f0 = flags_out;
        drive(1, 1'b1, 64'hC000_0000_0000_0001, 8'd1, 5'b00100);
        chk("R2", res_val, r0);
        chk("R2", {59'b0, flags_out}, {59'b0, f0});
    endtask

    task automatic t_sweep();
        logic [63:0] srcs[4] = '{64'hFFFF_FFFF_0000_0001, 64'h8000_0000_8000_0001,
                                 64'h0123_4567_89AB_CDEF, 64'h7FFF_FFFF_7FFF_FFFE};
        logic [7:0]  cnts[9] = '{8'd0, 8'd1, 8'd2, 8'd31, 8'd32, 8'd33,
                                 8'd63, 8'd64, 8'd255};
        for (int op = 0; op < 8; op++)
            for (int wd = 0; wd < 2; wd++)
                for (int si = 0; si < 4; si++)
                    for (int ci = 0; ci < 9; ci++)
                        for (int fi = 0; fi < 2; fi++) begin
                            drive(op, wd[0], srcs[si], cnts[ci],
                                  fi[0] ? 5'b01111 : 5'b00000);
                            compare_ref();
                        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_quiet();
        t_zero_count_upper();
        t_mask_high_bits();
        t_sal_matches_shl();
        t_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule